// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the chip's interrupt controller. Each channel reports expiry as a one-cycle event. The router turns that event into one of three outcomes: a held, level-style interrupt with a pending bit in a status vector, a single-cycle edge pulse, or a message-request strobe that carries an address and a data word. Each channel picks one of the output lines through its own route field. Lines from 16 upward are active-low, so the idle pattern is high on those lines.

The block also carries two outside legacy interrupt sources: a periodic-tick source and a clock-chip source. Each is registered and then passed to line 0 and line 8. When legacy replacement mode is on, both sources are masked. Channel 0 then owns line 0 and channel 1 owns line 8, whatever their route fields hold, and a timer-enable output for the old tick device goes low. Software acknowledges a level interrupt by writing ones to the status vector.

Top module: `irq_router`

## Requirements
- R1: While reset is held, and in the first cycle after reset, no status bit and no message request is set. Lines 0..15 are low and lines 16..31 are high, even when both legacy inputs are high during reset, because their registered copies are cleared. `pitEnable` is 1.
- R2: An expiry on a channel that is enabled, with global enable on, level mode (`chLevel`=1) and no message delivery, sets its status bit on the next clock edge. It also asserts the channel's routed line, and both stay set until cleared.
- R3: An expiry in edge mode (`chLevel`=0) leaves the channel's status bit at 0 and asserts its routed line for exactly one clock cycle.
- R4: A line numbered 16 or above is asserted by driving it low and is idle high. Lines below 16 are asserted high.
- R5: A status write (`statusWrEn`=1) clears, on the next edge, each status bit whose `statusWrData` bit is 1 and deasserts that channel's line. Status bits whose write bit is 0 are unchanged, and a 1 written for a channel that is not pending has no effect.
- R6: An expiry is ignored while `chEnable` of that channel or `globalEn` is 0. A pending status bit clears on the edge after either enable goes low.
- R7: With `chMsgEn`=1, an expiry produces a one-cycle `msgReq` bit for that channel. The channel's address and data words appear at bits [32c+31:32c] of `msgAddr` and `msgData`. No line is driven and no status bit is set.
- R8: In legacy mode (`legacyMode`=1), channel 0 drives line 0 and channel 1 drives line 8, regardless of their route fields. Any other channel routed to line 0 or line 8 does not drive it.
- R9: Outside legacy mode, `pitIn` and `rtcIn` appear on line 0 and line 8 one cycle after they are sampled. In legacy mode both inputs are masked from the lines, and `pitEnable` is 0.
- R10: The clock-chip input is registered every cycle, including in legacy mode. On leaving legacy mode, line 8 at once shows the level that was last registered.
- R11: If a level expiry and a status-write clear of the same channel arrive in the same cycle, the expiry wins and the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Global interrupt generation enable |
| legacyMode | input | 1 | Legacy replacement mode |
| chExpire | input | NUM_CH | Per-channel one-cycle expiry event |
| chEnable | input | NUM_CH | Per-channel interrupt enable |
| chLevel | input | NUM_CH | 1 = level mode, 0 = edge mode |
| chMsgEn | input | NUM_CH | 1 = deliver by message request |
| chRoute | input | NUM_CH*ROUTE_W | Route field of channel c at [ROUTE_W*c +: ROUTE_W] |
| chMsgAddr | input | NUM_CH*MSG_W | Message address per channel |
| chMsgData | input | NUM_CH*MSG_W | Message data per channel |
| statusWrEn | input | 1 | Status write strobe |
| statusWrData | input | NUM_CH | Write-one-to-clear mask |
| pitIn | input | 1 | Legacy periodic-tick interrupt input |
| rtcIn | input | 1 | Legacy clock-chip interrupt input |
| statusBits | output | NUM_CH | Pending level interrupts |
| msgReq | output | NUM_CH | One-cycle message request per channel |
| msgAddr | output | NUM_CH*MSG_W | Captured message address |
| msgData | output | NUM_CH*MSG_W | Captured message data |
| irqLines | output | NUM_LINES | Interrupt output lines |
| pitEnable | output | 1 | Enable for the legacy tick device |

## Verification
The case that needs care is a status write that clears a channel in the same cycle as a new level expiry on that channel. Setting and clearing then meet on one edge. The bench first makes channel 0 pending, then drives both its expiry and its clear bit on the same edge. Per R11, it expects the status bit and line 3 to remain asserted. A second test clears one of two pending channels to show the clear mask touches nothing else.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  // per-channel control strobes handed from control to datapath
  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic pulse;
    logic msg;
  } chStrobe_t;

  localparam int LEGACY_LINE_A   = 0;
  localparam int LEGACY_LINE_B   = 8;
  localparam int ACTIVE_LOW_BASE = 16;

endpackage

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irqr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                  globalEn,
  input  logic [NUM_CH-1:0]     chExpire,
  input  logic [NUM_CH-1:0]     chEnable,
  input  logic [NUM_CH-1:0]     chLevel,
  input  logic [NUM_CH-1:0]     chMsgEn,
  input  logic                  statusWrEn,
  input  logic [NUM_CH-1:0]     statusWrData,
  output chStrobe_t [NUM_CH-1:0] strobes
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic live, fire, edgeFire;
    assign live     = chEnable[c] & globalEn;
    assign fire     = chExpire[c] & live;
    assign edgeFire = fire & ~chLevel[c] & ~chMsgEn[c];

    assign strobes[c].setPend = fire & chLevel[c] & ~chMsgEn[c];
    assign strobes[c].pulse   = edgeFire;
    assign strobes[c].msg     = fire & chMsgEn[c];
    // suppression, acknowledge, or an edge event all drop the pending bit
    assign strobes[c].clrPend = ~live | (statusWrEn & statusWrData[c]) | edgeFire;
  end

endmodule

// File: rtl/irqr_dp.sv
module irqr_dp
  import irqr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 32,
  parameter int ROUTE_W   = 5,
  parameter int MSG_W     = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  chStrobe_t [NUM_CH-1:0]      strobes,
  input  logic                        legacyMode,
  input  logic [NUM_CH*ROUTE_W-1:0]   chRoute,
  input  logic [NUM_CH-1:0]           chMsgEn,
  input  logic [NUM_CH*MSG_W-1:0]     chMsgAddr,
  input  logic [NUM_CH*MSG_W-1:0]     chMsgData,
  input  logic                        pitIn,
  input  logic                        rtcIn,
  output logic [NUM_CH-1:0]           statusBits,
  output logic [NUM_CH-1:0]           msgReq,
  output logic [NUM_CH*MSG_W-1:0]     msgAddr,
  output logic [NUM_CH*MSG_W-1:0]     msgData,
  output logic [NUM_LINES-1:0]        irqLines
);

  logic [NUM_CH-1:0] pend, pulseQ;
  logic              pitQ, rtcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= '0;
      pulseQ  <= '0;
      msgReq  <= '0;
      msgAddr <= '0;
      msgData <= '0;
      pitQ    <= 1'b0;
      rtcQ    <= 1'b0;
    end else begin
      pitQ <= pitIn;
      rtcQ <= rtcIn;
      for (int c = 0; c < NUM_CH; c++) begin
        if (strobes[c].setPend)      pend[c] <= 1'b1;
        else if (strobes[c].clrPend) pend[c] <= 1'b0;
        pulseQ[c] <= strobes[c].pulse;
        msgReq[c] <= strobes[c].msg;
        if (strobes[c].msg) begin
          msgAddr[c*MSG_W +: MSG_W] <= chMsgAddr[c*MSG_W +: MSG_W];
          msgData[c*MSG_W +: MSG_W] <= chMsgData[c*MSG_W +: MSG_W];
        end
      end
    end
  end

  assign statusBits = pend;

  // per-channel effective target line
  int   tgt   [NUM_CH];
  logic tgtOk [NUM_CH];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (legacyMode && c < 2) begin
        tgt[c]   = (c == 0) ? LEGACY_LINE_A : LEGACY_LINE_B;
        tgtOk[c] = 1'b1;
      end else begin
        tgt[c]   = int'(chRoute[c*ROUTE_W +: ROUTE_W]);
        tgtOk[c] = (tgt[c] < NUM_LINES) &&
                   !(legacyMode && (tgt[c] == LEGACY_LINE_A || tgt[c] == LEGACY_LINE_B));
      end
    end
  end

  logic [NUM_LINES-1:0] active;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      active[l] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if ((pend[c] | pulseQ[c]) && !chMsgEn[c] && tgtOk[c] && tgt[c] == l)
          active[l] = 1'b1;
      end
    end
    if (!legacyMode) begin
      active[LEGACY_LINE_A] = active[LEGACY_LINE_A] | pitQ;
      active[LEGACY_LINE_B] = active[LEGACY_LINE_B] | rtcQ;
    end
    for (int l = 0; l < NUM_LINES; l++)
      irqLines[l] = (l >= ACTIVE_LOW_BASE) ? ~active[l] : active[l];
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irqr_pkg::*;
#(
  parameter  int NUM_CH    = 3,
  parameter  int NUM_LINES = 32,
  parameter  int MSG_W     = 32,
  localparam int ROUTE_W   = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      globalEn,
  input  logic                      legacyMode,
  input  logic [NUM_CH-1:0]         chExpire,
  input  logic [NUM_CH-1:0]         chEnable,
  input  logic [NUM_CH-1:0]         chLevel,
  input  logic [NUM_CH-1:0]         chMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0] chRoute,
  input  logic [NUM_CH*MSG_W-1:0]   chMsgAddr,
  input  logic [NUM_CH*MSG_W-1:0]   chMsgData,
  input  logic                      statusWrEn,
  input  logic [NUM_CH-1:0]         statusWrData,
  input  logic                      pitIn,
  input  logic                      rtcIn,
  output logic [NUM_CH-1:0]         statusBits,
  output logic [NUM_CH-1:0]         msgReq,
  output logic [NUM_CH*MSG_W-1:0]   msgAddr,
  output logic [NUM_CH*MSG_W-1:0]   msgData,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic                      pitEnable
);

  chStrobe_t [NUM_CH-1:0] strobes;

  irqr_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .globalEn     (globalEn),
    .chExpire     (chExpire),
    .chEnable     (chEnable),
    .chLevel      (chLevel),
    .chMsgEn      (chMsgEn),
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .strobes      (strobes)
  );

  irqr_dp #(
    .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W), .MSG_W(MSG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .legacyMode (legacyMode),
    .chRoute    (chRoute),
    .chMsgEn    (chMsgEn),
    .chMsgAddr  (chMsgAddr),
    .chMsgData  (chMsgData),
    .pitIn      (pitIn),
    .rtcIn      (rtcIn),
    .statusBits (statusBits),
    .msgReq     (msgReq),
    .msgAddr    (msgAddr),
    .msgData    (msgData),
    .irqLines   (irqLines)
  );

  // the legacy tick device is silenced while its line is taken over
  assign pitEnable = ~legacyMode;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalEn,
  input logic [NUM_CH-1:0] chExpire,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] chLevel,
  input logic [NUM_CH-1:0] chMsgEn,
  input logic              statusWrEn,
  input logic [NUM_CH-1:0] statusWrData,
  input logic [NUM_CH-1:0] statusBits,
  input logic [NUM_CH-1:0] msgReq
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_level_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
      chExpire[c] && chEnable[c] && globalEn && chLevel[c] && !chMsgEn[c]
      |=> statusBits[c]);

    p_edge_no_status_r3: assert property (@(posedge clk) disable iff (!rstN)
      chExpire[c] && chEnable[c] && globalEn && !chLevel[c] && !chMsgEn[c]
      |=> !statusBits[c]);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
      statusWrEn && statusWrData[c] && !chExpire[c] |=> !statusBits[c]);

    p_suppress_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(chEnable[c] && globalEn) |=> !statusBits[c] && !msgReq[c]);

    p_msg_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
      chExpire[c] && chEnable[c] && globalEn && chMsgEn[c]
      |=> msgReq[c] && (statusBits[c] == $past(statusBits[c]) || !statusBits[c]));

    p_msg_single_r7: assert property (@(posedge clk) disable iff (!rstN)
      !chExpire[c] |=> !msgReq[c]);

    p_set_beats_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
      statusWrEn && statusWrData[c] && chExpire[c] && chEnable[c] && globalEn &&
      chLevel[c] && !chMsgEn[c] |=> statusBits[c]);
  end

endmodule

bind irq_router irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .globalEn     (globalEn),
  .chExpire     (chExpire),
  .chEnable     (chEnable),
  .chLevel      (chLevel),
  .chMsgEn      (chMsgEn),
  .statusWrEn   (statusWrEn),
  .statusWrData (statusWrData),
  .statusBits   (statusBits),
  .msgReq       (msgReq)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam int NC = 3;
  localparam int NL = 32;
  localparam int RW = 5;
  localparam int MW = 32;
  localparam logic [NL-1:0] IDLE = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rstN, globalEn, legacyMode, statusWrEn, pitIn, rtcIn;
  logic [NC-1:0] chExpire, chEnable, chLevel, chMsgEn, statusWrData;
  logic [NC*RW-1:0] chRoute;
  logic [NC*MW-1:0] chMsgAddr, chMsgData;
  logic [NC-1:0] statusBits, msgReq;
  logic [NC*MW-1:0] msgAddr, msgData;
  logic [NL-1:0] irqLines;
  logic pitEnable;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .legacyMode(legacyMode),
    .chExpire(chExpire), .chEnable(chEnable), .chLevel(chLevel), .chMsgEn(chMsgEn),
    .chRoute(chRoute), .chMsgAddr(chMsgAddr), .chMsgData(chMsgData),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .pitIn(pitIn), .rtcIn(rtcIn),
    .statusBits(statusBits), .msgReq(msgReq), .msgAddr(msgAddr), .msgData(msgData),
    .irqLines(irqLines), .pitEnable(pitEnable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] ln(input int idx);
    return NL'(1) << idx;
  endfunction

  task automatic setRoutes(input int r0, input int r1, input int r2);
    chRoute = {RW'(r2), RW'(r1), RW'(r0)};
  endtask

  // one-cycle expiry, returns at the following falling edge
  task automatic fire(input logic [NC-1:0] m);
    chExpire = m;
    @(negedge clk);
    chExpire = '0;
  endtask

  task automatic ack(input logic [NC-1:0] m);
    statusWrEn = 1'b1; statusWrData = m;
    @(negedge clk);
    statusWrEn = 1'b0; statusWrData = '0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; pitIn = 1'b1; rtcIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lines in reset", 64'(irqLines), 64'(IDLE));
    chk("R1 status in reset", 64'(statusBits), 64'd0);
    chk("R1 msgReq in reset", 64'(msgReq), 64'd0);
    chk("R1 pitEnable", 64'(pitEnable), 64'd1);
    pitIn = 1'b0; rtcIn = 1'b0; rstN = 1'b1;
    @(negedge clk);
    chk("R1 lines after reset", 64'(irqLines), 64'(IDLE));
  endtask

  task automatic t_level();
    fire(3'b001);
    chk("R2 status set", 64'(statusBits), 64'b001);
    chk("R2 line 3 asserted", 64'(irqLines), 64'(IDLE ^ ln(3)));
    @(negedge clk);
    chk("R2 line held", 64'(irqLines), 64'(IDLE ^ ln(3)));
    ack(3'b100);
    chk("R5 non-pending ack no effect", 64'(statusBits), 64'b001);
    ack(3'b001);
    chk("R5 ack clears status", 64'(statusBits), 64'd0);
    chk("R5 ack drops line", 64'(irqLines), 64'(IDLE));
  endtask

  task automatic t_lowline();
    fire(3'b010);
    chk("R4 line 20 driven low", 64'(irqLines), 64'(IDLE ^ ln(20)));
    chk("R2 ch1 status", 64'(statusBits), 64'b010);
    ack(3'b010);
    chk("R4 line 20 idle high", 64'(irqLines), 64'(IDLE));
  endtask

  task automatic t_edge();
    fire(3'b100);
    chk("R3 edge status clear", 64'(statusBits), 64'd0);
    chk("R3 pulse on line 5", 64'(irqLines), 64'(IDLE ^ ln(5)));
    @(negedge clk);
    chk("R3 pulse one cycle", 64'(irqLines), 64'(IDLE));
    setRoutes(3, 20, 17);
    fire(3'b100);
    chk("R4 low pulse line 17", 64'(irqLines), 64'(IDLE ^ ln(17)));
    @(negedge clk);
    chk("R3 line 17 back high", 64'(irqLines), 64'(IDLE));
    setRoutes(3, 20, 5);
  endtask

  task automatic t_two();
    fire(3'b011);
    chk("R2 two pending", 64'(statusBits), 64'b011);
    ack(3'b001);
    chk("R5 partial ack status", 64'(statusBits), 64'b010);
    chk("R5 partial ack lines", 64'(irqLines), 64'(IDLE ^ ln(20)));
    ack(3'b010);
  endtask

  task automatic t_disable();
    chEnable = 3'b110;
    fire(3'b001);
    chk("R6 channel disabled", 64'(statusBits), 64'd0);
    chk("R6 channel disabled lines", 64'(irqLines), 64'(IDLE));
    chEnable = 3'b111; globalEn = 1'b0;
    fire(3'b001);
    chk("R6 global disabled", 64'(statusBits), 64'd0);
    globalEn = 1'b1;
    fire(3'b001);
    chEnable = 3'b110;
    @(negedge clk);
    chk("R6 disable clears pending", 64'(statusBits), 64'd0);
    chk("R6 disable drops line", 64'(irqLines), 64'(IDLE));
    chEnable = 3'b111;
  endtask

  task automatic t_msg();
    chMsgEn = 3'b010;
    chMsgAddr[MW +: MW] = 32'hFEE0_1000;
    chMsgData[MW +: MW] = 32'h0000_0041;
    fire(3'b010);
    chk("R7 msgReq", 64'(msgReq), 64'b010);
    chk("R7 msgAddr", 64'(msgAddr[MW +: MW]), 64'hFEE0_1000);
    chk("R7 msgData", 64'(msgData[MW +: MW]), 64'h41);
    chk("R7 no status", 64'(statusBits), 64'd0);
    chk("R7 no line", 64'(irqLines), 64'(IDLE));
    @(negedge clk);
    chk("R7 msgReq single cycle", 64'(msgReq), 64'd0);
    chMsgEn = '0;
  endtask

  task automatic t_legacy();
    legacyMode = 1'b1; pitIn = 1'b1; rtcIn = 1'b1;
    chLevel = 3'b111; setRoutes(3, 20, 0);
    @(negedge clk);
    chk("R9 inputs masked in legacy", 64'(irqLines), 64'(IDLE));
    chk("R9 pitEnable low", 64'(pitEnable), 64'd0);
    fire(3'b111);
    chk("R8 legacy status", 64'(statusBits), 64'b111);
    chk("R8 fixed legacy routes", 64'(irqLines), 64'(IDLE ^ ln(0) ^ ln(8)));
    ack(3'b111);
    chk("R8 legacy cleared", 64'(irqLines), 64'(IDLE));
  endtask

  task automatic t_restore();
    // still in legacy with both inputs high for several cycles
    legacyMode = 1'b0; rtcIn = 1'b0; pitIn = 1'b0;
    #1;
    chk("R10 latched levels shown", 64'(irqLines), 64'(IDLE ^ ln(0) ^ ln(8)));
    chk("R9 pitEnable restored", 64'(pitEnable), 64'd1);
    @(negedge clk);
    chk("R10 follows new level", 64'(irqLines), 64'(IDLE));
    chLevel = 3'b011; setRoutes(3, 20, 5);
  endtask

  task automatic t_pass();
    pitIn = 1'b1;
    @(negedge clk);
    chk("R9 pit passes to line 0", 64'(irqLines), 64'(IDLE ^ ln(0)));
    pitIn = 1'b0; rtcIn = 1'b1;
    @(negedge clk);
    chk("R9 rtc passes to line 8", 64'(irqLines), 64'(IDLE ^ ln(8)));
    rtcIn = 1'b0;
    @(negedge clk);
    chk("R9 inputs low", 64'(irqLines), 64'(IDLE));
  endtask

  task automatic t_collide();
    fire(3'b001);
    chExpire = 3'b001; statusWrEn = 1'b1; statusWrData = 3'b001;
    @(negedge clk);
    chExpire = '0; statusWrEn = 1'b0; statusWrData = '0;
    chk("R11 set beats ack status", 64'(statusBits), 64'b001);
    chk("R11 set beats ack line", 64'(irqLines), 64'(IDLE ^ ln(3)));
    ack(3'b001);
    chk("R5 final clear", 64'(statusBits), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    globalEn = 1'b1; legacyMode = 1'b0; chExpire = '0; chEnable = 3'b111;
    chLevel = 3'b011; chMsgEn = '0; statusWrEn = 1'b0; statusWrData = '0;
    chMsgAddr = '0; chMsgData = '0; setRoutes(3, 20, 5);
    t_reset();
    t_level();
    t_lowline();
    t_edge();
    t_two();
    t_disable();
    t_msg();
    t_legacy();
    t_restore();
    t_pass();
    t_collide();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule